// File: doc/BRIEF.md
# Serial Input Message Decoder

This block takes a bit-serial stream of keyboard and pointing-device messages and turns each completed message into a write on a small register file. One bit arrives for each cycle in which `bit_valid` is high. The first three bits of a message select its type. The following sixteen bits form the payload. A running count of the 1 bits over the whole message decides whether keyboard messages are accepted.

The register file holds seven 16-bit words: four keyboard words, one word for the keyset and mouse switches, and a mouse X/Y position pair. Mouse messages do not overwrite the position. They carry two signed 8-bit deltas that are added to the stored X and Y. Each register write raises that register's bit of `wr_pulse` for one cycle. Any register can be read at any time through an address-indexed read port.

Top module: `serial_msg_decoder`

## Requirements
- R1: After reset, the four keyboard words read 16'hFFFF, and the switch word, X and Y read 16'h0000. `wr_pulse` is zero.
- R2: The first three bits received form a code, first bit most significant, and the message type is code+1. Code 7 wraps to type 0, which writes nothing.
- R3: The next 16 bits received form the payload, first bit most significant. The message completes on the 16th payload bit. A new message may start in the very next cycle.
- R4: Types 1 to 4 write the payload to keyboard words 0 to 3 (register indices 0 to 3). The write happens only if the message's 19 bits held at least eight 1 bits.
- R5: Type 5 writes the payload to the switch word (index 4) whatever its count of 1 bits.
- R6: Type 6 adds the sign-extended payload[15:8] to X (index 5) and the sign-extended payload[7:0] to Y (index 6), modulo 2^16.
- R7: A type 7 message changes no register and raises no pulse.
- R8: `wr_pulse[i]` is high for exactly one cycle per write of register i. That is the first cycle in which the new value is readable, and a register never changes without its pulse.
- R9: `rd_data` shows register `rd_addr` in the same cycle. Address 7 reads zero.
- R10: A cycle with `bit_valid` low is ignored, whatever `bit_in` holds.
- R11: The type and the count of 1 bits are cleared after every completed message, so counts from one message never carry into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial message bit |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 16 | Contents of the indexed register |
| wr_pulse | output | 7 | One-cycle write strobe per register |

## Verification
The bench targets the keyboard acceptance threshold at exactly seven and exactly eight 1 bits. A design that counted only payload bits, or compared with the wrong relation, would store the seven-bit case or drop the eight-bit one.

Mouse deltas with the top bit set are applied so that X and Y go negative. A design without sign extension would move them by +128 instead.

A heavy message is followed by a light one to the same keyboard word. A count that survived the first message would let the second through.

Gapped input with `bit_in` toggling while invalid, and back-to-back messages with no idle cycle, show whether invalid cycles are skipped and whether the completion cycle loses the first bit of the next message.

// File: rtl/smd_pkg.sv
package smd_pkg;
   // Register file layout: keyboard words first, then switch, X, Y
   localparam int KB_WORDS   = 4;
   localparam int IDX_SWITCH = KB_WORDS;
   localparam int IDX_X      = KB_WORDS + 1;
   localparam int IDX_Y      = KB_WORDS + 2;
   localparam int NUM_REGS   = KB_WORDS + 3;

   // Decoded message types (code + 1)
   typedef enum logic [2:0] {
      MT_NONE   = 3'd0,
      MT_KB0    = 3'd1,
      MT_KB1    = 3'd2,
      MT_KB2    = 3'd3,
      MT_KB3    = 3'd4,
      MT_SWITCH = 3'd5,
      MT_MOUSE  = 3'd6,
      MT_IGNORE = 3'd7
   } msg_type_e;
endpackage

// File: rtl/smd_shifter.sv
module smd_shifter #(
   parameter int TYPE_W = 3,
   parameter int DATA_W = 16,
   parameter int CNT_W  = $clog2(TYPE_W + DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic              bit_in,
   output logic              done_vld,
   output logic [TYPE_W-1:0] done_type,
   output logic [DATA_W-1:0] done_payload,
   output logic [CNT_W-1:0]  done_ones
);
   localparam int SH_W = DATA_W + 1;

   logic              in_payload;
   logic [SH_W-1:0]   sh_q;
   logic [SH_W-1:0]   sh_next;
   logic [TYPE_W-1:0] type_q;
   logic [CNT_W-1:0]  ones_q;
   logic [CNT_W-1:0]  ones_next;
   logic              type_full;
   logic              msg_full;

   // Marker bit rides in front of the received bits; its arrival at a
   // fixed position ends the current field.
   assign sh_next   = {sh_q[SH_W-2:0], bit_in};
   assign ones_next = ones_q + CNT_W'(bit_in);
   assign type_full = !in_payload && sh_next[TYPE_W];
   assign msg_full  = in_payload && sh_next[DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_payload   <= 1'b0;
         sh_q         <= SH_W'(1);
         type_q       <= '0;
         ones_q       <= '0;
         done_vld     <= 1'b0;
         done_type    <= '0;
         done_payload <= '0;
         done_ones    <= '0;
      end else begin
         done_vld <= 1'b0;
         if (bit_valid) begin
            if (type_full) begin
               type_q     <= sh_next[TYPE_W-1:0] + TYPE_W'(1);
               sh_q       <= SH_W'(1);
               in_payload <= 1'b1;
               ones_q     <= ones_next;
            end else if (msg_full) begin
               done_vld     <= 1'b1;
               done_type    <= type_q;
               done_payload <= sh_next[DATA_W-1:0];
               done_ones    <= ones_next;
               type_q       <= '0;
               ones_q       <= '0;
               sh_q         <= SH_W'(1);
               in_payload   <= 1'b0;
            end else begin
               sh_q   <= sh_next;
               ones_q <= ones_next;
            end
         end
      end
   end
endmodule

// File: rtl/smd_decode.sv
module smd_decode
   import smd_pkg::*;
#(
   parameter int TYPE_W   = 3,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 5,
   parameter int MIN_ONES = 8
) (
   input  logic                             done_vld,
   input  logic [TYPE_W-1:0]                done_type,
   input  logic [DATA_W-1:0]                done_payload,
   input  logic [CNT_W-1:0]                 done_ones,
   input  logic [DATA_W-1:0]                cur_x,
   input  logic [DATA_W-1:0]                cur_y,
   output logic [NUM_REGS-1:0]              we,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  wdata
);
   localparam int DELTA_W = DATA_W / 2;

   logic              kb_ok;
   logic [DATA_W-1:0] dx_ext;
   logic [DATA_W-1:0] dy_ext;

   assign kb_ok = done_ones >= CNT_W'(MIN_ONES);

   // Sign extension of each packed delta to full word width
   assign dx_ext = {{(DATA_W-DELTA_W){done_payload[DATA_W-1]}},
                    done_payload[DATA_W-1:DATA_W-DELTA_W]};
   assign dy_ext = {{(DATA_W-DELTA_W){done_payload[DELTA_W-1]}},
                    done_payload[DELTA_W-1:0]};

   for (genvar k = 0; k < KB_WORDS; k++) begin : g_kb
      assign we[k]    = done_vld && kb_ok &&
                        (done_type == TYPE_W'(int'(MT_KB0) + k));
      assign wdata[k] = done_payload;
   end

   assign we[IDX_SWITCH]    = done_vld && (done_type == TYPE_W'(MT_SWITCH));
   assign wdata[IDX_SWITCH] = done_payload;

   assign we[IDX_X]    = done_vld && (done_type == TYPE_W'(MT_MOUSE));
   assign we[IDX_Y]    = we[IDX_X];
   assign wdata[IDX_X] = cur_x + dx_ext;
   assign wdata[IDX_Y] = cur_y + dy_ext;
endmodule

// File: rtl/smd_regfile.sv
module smd_regfile
   import smd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int RD_W   = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_REGS-1:0]              we,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  wdata,
   input  logic [RD_W-1:0]                  rd_addr,
   output logic [DATA_W-1:0]                rd_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
   output logic [NUM_REGS-1:0]              wr_pulse
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      // Keyboard words idle high (no key down); others start at zero
      localparam logic [DATA_W-1:0] RST_VAL = (i < KB_WORDS) ? '1 : '0;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs[i]     <= RST_VAL;
            wr_pulse[i] <= 1'b0;
         end else begin
            wr_pulse[i] <= we[i];
            if (we[i]) regs[i] <= wdata[i];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == RD_W'(i)) rd_data = regs[i];
      end
   end
endmodule

// File: rtl/serial_msg_decoder.sv
module serial_msg_decoder
   import smd_pkg::*;
#(
   parameter int TYPE_W   = 3,
   parameter int DATA_W   = 16,
   parameter int MIN_ONES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_valid,
   input  logic                bit_in,
   input  logic [2:0]          rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_REGS-1:0] wr_pulse
);
   localparam int CNT_W = $clog2(TYPE_W + DATA_W + 1);
   localparam int RD_W  = 3;

   initial begin
      if (TYPE_W != 3) $fatal(1, "type field must be 3 bits");
      if (DATA_W < 4 || (DATA_W % 2) != 0) $fatal(1, "payload width must be even, >= 4");
      if (MIN_ONES > TYPE_W + DATA_W) $fatal(1, "threshold exceeds message length");
      if ((1 << RD_W) < NUM_REGS) $fatal(1, "read address too narrow");
   end

   logic                             done_vld;
   logic [TYPE_W-1:0]                done_type;
   logic [DATA_W-1:0]                done_payload;
   logic [CNT_W-1:0]                 done_ones;
   logic [NUM_REGS-1:0]              we;
   logic [NUM_REGS-1:0][DATA_W-1:0]  wdata;
   logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

   smd_shifter #(.TYPE_W(TYPE_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_valid    (bit_valid),
      .bit_in       (bit_in),
      .done_vld     (done_vld),
      .done_type    (done_type),
      .done_payload (done_payload),
      .done_ones    (done_ones)
   );

   smd_decode #(.TYPE_W(TYPE_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                .MIN_ONES(MIN_ONES)) u_dec (
      .done_vld     (done_vld),
      .done_type    (done_type),
      .done_payload (done_payload),
      .done_ones    (done_ones),
      .cur_x        (regs[IDX_X]),
      .cur_y        (regs[IDX_Y]),
      .we           (we),
      .wdata        (wdata)
   );

   smd_regfile #(.DATA_W(DATA_W), .RD_W(RD_W)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we),
      .wdata    (wdata),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .regs     (regs),
      .wr_pulse (wr_pulse)
   );
endmodule

// File: rtl/smd_checker.sv
module smd_checker
   import smd_pkg::*;
#(
   parameter int TYPE_W   = 3,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 5,
   parameter int MIN_ONES = 8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             done_vld,
   input logic [TYPE_W-1:0]                done_type,
   input logic [CNT_W-1:0]                 done_ones,
   input logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
   input logic [NUM_REGS-1:0]              wr_pulse
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_per_reg
      p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
         wr_pulse[i] |=> !wr_pulse[i]);
      p_change_has_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (regs[i] != $past(regs[i])) |-> wr_pulse[i]);
   end

   p_ignored_types_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && (done_type == TYPE_W'(MT_IGNORE) || done_type == TYPE_W'(MT_NONE)))
      |=> (wr_pulse == '0));

   p_kb_threshold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && done_type >= TYPE_W'(MT_KB0) && done_type <= TYPE_W'(MT_KB3)
       && done_ones < CNT_W'(MIN_ONES)) |=> (wr_pulse == '0));

   p_switch_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && done_type == TYPE_W'(MT_SWITCH))
      |=> (wr_pulse == NUM_REGS'(1 << IDX_SWITCH)));

   p_mouse_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && done_type == TYPE_W'(MT_MOUSE))
      |=> (wr_pulse[IDX_X] && wr_pulse[IDX_Y] && $countones(wr_pulse) == 2));
endmodule

bind serial_msg_decoder smd_checker #(
   .TYPE_W(TYPE_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_ONES(MIN_ONES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done_vld  (done_vld),
   .done_type (done_type),
   .done_ones (done_ones),
   .regs      (regs),
   .wr_pulse  (wr_pulse)
);

// File: tb/serial_msg_decoder_tb.sv
module serial_msg_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_valid = 1'b0;
   logic        bit_in = 1'b0;
   logic [2:0]  rd_addr = 3'd0;
   logic [15:0] rd_data;
   logic [6:0]  wr_pulse;

   int checks = 0;
   int fails = 0;
   logic [6:0] seen = '0;
   int pulse_cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   serial_msg_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_pulse(wr_pulse)
   );

   // code[44:42] payload[41:26] addr[25:23] expected[22:7] pulse mask[6:0]
   localparam logic [44:0] VEC [13] = '{
      {3'd0, 16'hFF00, 3'd0, 16'hFF00, 7'h01},  // R4 exactly eight ones
      {3'd1, 16'h007F, 3'd1, 16'h007F, 7'h02},  // R4 type bit counts
      {3'd2, 16'h003F, 3'd2, 16'hFFFF, 7'h00},  // R4 seven ones dropped
      {3'd3, 16'h0F0F, 3'd3, 16'h0F0F, 7'h08},  // R4
      {3'd4, 16'h0001, 3'd4, 16'h0001, 7'h10},  // R5 few ones still written
      {3'd5, 16'h0305, 3'd5, 16'h0003, 7'h60},  // R6 positive
      {3'd5, 16'hFEFF, 3'd6, 16'h0004, 7'h60},  // R6 negative deltas
      {3'd5, 16'h8080, 3'd5, 16'hFF81, 7'h60},  // R6 most negative X
      {3'd6, 16'hFFFF, 3'd0, 16'hFF00, 7'h00},  // R7 ignored
      {3'd7, 16'hFFFF, 3'd4, 16'h0001, 7'h00},  // R2 code 7 wraps, ignored
      {3'd0, 16'h0000, 3'd0, 16'hFF00, 7'h00},  // R4 zero ones dropped
      {3'd3, 16'h00FF, 3'd3, 16'h00FF, 7'h08},  // R3 payload order
      {3'd5, 16'h0000, 3'd6, 16'hFF84, 7'h60}   // R6 zero deltas, Y held
   };

   always @(negedge clk) begin
      if (rst_n) begin
         seen <= seen | wr_pulse;
         pulse_cycles <= pulse_cycles + $countones(wr_pulse);
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bit(logic b, bit gap);
      if (gap) begin
         @(negedge clk);
         bit_valid = 1'b0;
         bit_in = ~b;
      end
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in = b;
   endtask

   task automatic send_msg(logic [2:0] code, logic [15:0] pl, bit gap);
      for (int i = 2; i >= 0; i--) send_bit(code[i], gap);
      for (int i = 15; i >= 0; i--) send_bit(pl[i], gap);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_valid = 1'b0;
         bit_in = 1'b0;
      end
   endtask

   task automatic clear_mon();
      @(negedge clk);
      #1;
      seen = '0;
      pulse_cycles = 0;
   endtask

   task automatic read_chk(string req, logic [2:0] a, logic [15:0] exp);
      rd_addr = a;
      #1;
      chk(req, {16'h0, rd_data}, {16'h0, exp});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      for (int a = 0; a < 7; a++)
         read_chk("R1", 3'(a), (a < 4) ? 16'hFFFF : 16'h0000);
      chk("R1 pulse", {25'h0, wr_pulse}, 32'h0);
      // R9 unused address
      read_chk("R9", 3'd7, 16'h0000);

      // table walk
      for (int v = 0; v < 13; v++) begin
         clear_mon();
         send_msg(VEC[v][44:42], VEC[v][41:26], 1'b0);
         idle(4);
         read_chk($sformatf("vec%0d data", v), VEC[v][25:23], VEC[v][22:7]);
         chk($sformatf("vec%0d R8 mask", v), {25'h0, seen}, {25'h0, VEC[v][6:0]});
         chk($sformatf("vec%0d R8 single", v), pulse_cycles, $countones(VEC[v][6:0]));
      end

      // R10 gaps with bit_in toggling while invalid
      clear_mon();
      send_msg(3'd4, 16'hA5A5, 1'b1);
      idle(4);
      read_chk("R10", 3'd4, 16'hA5A5);
      chk("R10 mask", {25'h0, seen}, 32'h10);

      // R11 heavy message then light message to same word
      clear_mon();
      send_msg(3'd0, 16'h0FFF, 1'b0);
      idle(4);
      read_chk("R11 first", 3'd0, 16'h0FFF);
      send_msg(3'd0, 16'h0001, 1'b0);
      idle(4);
      read_chk("R11 second dropped", 3'd0, 16'h0FFF);
      chk("R11 mask", {25'h0, seen}, 32'h01);

      // R3 back-to-back messages without idle
      clear_mon();
      send_msg(3'd4, 16'h1234, 1'b0);
      send_msg(3'd1, 16'hF0F0, 1'b0);
      idle(4);
      read_chk("R3 first", 3'd4, 16'h1234);
      read_chk("R3 second", 3'd1, 16'hF0F0);
      chk("R3 mask", {25'h0, seen}, 32'h12);
      read_chk("R9 addr7 after writes", 3'd7, 16'h0000);

      finish_run();
   end
endmodule